// File: doc/BRIEF.md
# Parallel EEPROM Write Controller with Toggle Polling

This block writes to a byte-wide parallel EEPROM over a plain asynchronous bus made of a chip select, a read strobe, a write strobe, an address and a data bus split into output, output-enable and input. A host asks for a single-byte write or for a burst of up to one page of consecutive bytes. The block does not wait a fixed worst-case time after the last byte. Instead it keeps reading the last address written until two reads in a row agree on data bit 6. It then makes one more read to confirm that the stored byte matches what was written. A counter derived from the clock frequency caps the polling at the worst-case internal write time and reports a timeout if polling runs past it.

A third mode checks whether write protection is active. It reads address 0, writes the bitwise complement of that byte, polls, and reads the byte back. If the byte is unchanged, protection is reported on. If the byte now holds the complement, protection is reported off and the original byte is written back, with its own poll and confirming read.

During a page write the host supplies data through an index handshake. The block shows the byte index on `host_idx`, and the host presents the matching byte on `host_wdata` in the same cycle.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is low, `mem_cs_n`, `mem_rd_n` and `mem_wr_n` are high and `mem_dq_oe` is low.
- R2: When `start` is seen while idle with `mode` = 2'b00, the block writes `host_wdata` to `host_addr` with exactly one `mem_wr_n` low pulse. After a successful poll and check it gives a one-cycle `done` pulse, and `fail_code` stays 2'b00.
- R3: When `mode` = 2'b01, the block writes `host_last`+1 bytes to the consecutive addresses `host_addr`+i. Each byte i is the value of `host_wdata` while `host_idx` = i. There is one `mem_wr_n` pulse per byte and a single completion wait after the last byte only. Addresses outside the burst are left untouched.
- R4: Polling reads the last address written. It ends when two consecutive reads agree on bit 6, and is followed by exactly one checking read. A write the device finishes after N toggling reads therefore costs N+2 or N+3 reads in total.
- R5: Every read bus cycle has exactly one `mem_rd_n` low pulse while `mem_cs_n` is low. `mem_rd_n` and `mem_wr_n` are never low together. `mem_addr` is stable while `mem_cs_n` stays low.
- R6: If polling has not finished within (CLK_HZ/1000)*WR_MS clock cycles of the last write, the block ends at the next poll read with a `fail` pulse and `fail_code` = 2'b01, and with no `done`.
- R7: If the checking read after polling differs from the byte written, the block ends with a `fail` pulse and `fail_code` = 2'b10. `fail_code` returns to 2'b00 when the next request is accepted.
- R8: When `mode` = 2'b10 and the byte at address 0 is unchanged after its complement was written and polled, the block sets `prot_on` = 1 and pulses `done`. It makes exactly one write.
- R9: When `mode` = 2'b10 and the byte at address 0 took the complement, the block sets `prot_on` = 0 and writes the original byte back with its own poll and check. It makes two writes in total, and address 0 ends holding its original value.
- R10: `busy` is high from the accepted `start` until the cycle that carries `done` or `fail`. A `start` while busy is ignored, and `start` with `mode` = 2'b11 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| mode | input | 2 | 00 byte, 01 page, 10 protection probe, 11 none |
| host_addr | input | ADDR_W | Target or base address |
| host_last | input | PAGE_W | Page mode: byte count minus one |
| host_wdata | input | 8 | Data for byte `host_idx` |
| host_idx | output | PAGE_W | Index of the byte being written |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| fail_code | output | 2 | 00 none, 01 timeout, 10 verify mismatch |
| prot_on | output | 1 | Result of the last protection probe |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | 8 | Write data toward memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_i | input | 8 | Read data from memory |

## Verification
Single-byte writes are swept over device busy lengths of 0 to 12 toggling reads. The read count then tells true bit-6 polling apart from a fixed delay, and tells it apart from a poll that stops one read early or one read late. Page writes are swept over every length from 1 to 64 against a pre-filled page. This separates the per-byte writes and the index handshake from the single final wait, and any overrun past the burst shows up in the sentinel bytes. A device that never settles, one that stores corrupted data, and protection probes with several original bytes in both the protected and unprotected states separate the timeout, mismatch, report-on and restore paths. Starts with the reserved mode, or during a busy operation, must leave the memory and the strobe counts unchanged.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;

    localparam int DATA_W   = 8;
    localparam int POLL_BIT = 6;

    localparam logic [1:0] MD_BYTE  = 2'b00;
    localparam logic [1:0] MD_PAGE  = 2'b01;
    localparam logic [1:0] MD_PROBE = 2'b10;

    localparam logic [1:0] FC_NONE    = 2'b00;
    localparam logic [1:0] FC_TIMEOUT = 2'b01;
    localparam logic [1:0] FC_VERIFY  = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PROBE = 3'd1,
        S_WRITE = 3'd2,
        S_POLL1 = 3'd3,
        S_POLL  = 3'd4,
        S_CHECK = 3'd5
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_USER    = 2'd0,
        PH_PROBE   = 2'd1,
        PH_RESTORE = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        B_IDLE   = 2'd0,
        B_SETUP  = 2'd1,
        B_STROBE = 2'd2,
        B_HOLD   = 2'd3
    } bus_state_e;

endpackage

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
    parameter int LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // saturating up-counter, restarted by clr
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/eeprom_bus_cycle.sv
module eeprom_bus_cycle
    import eeprom_wr_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int STROBE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_i
);
    localparam int SW = $clog2(STROBE_CYC + 1);

    typedef struct packed {
        bus_state_e        st;
        logic [SW-1:0]     cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } bus_t;

    bus_t b_d, b_q;

    // one cycle: select and address, then STROBE_CYC strobe cycles, then one hold
    always_comb begin
        b_d = b_q;
        unique case (b_q.st)
            B_IDLE: begin
                if (req) begin
                    b_d.st    = B_SETUP;
                    b_d.wr    = wr;
                    b_d.addr  = addr;
                    b_d.wdata = wdata;
                end
            end
            B_SETUP: begin
                b_d.st  = B_STROBE;
                b_d.cnt = '0;
            end
            B_STROBE: begin
                if (b_q.cnt == SW'(STROBE_CYC - 1)) begin
                    b_d.st = B_HOLD;
                    if (!b_q.wr) begin
                        b_d.rdata = dq_i;
                    end
                end else begin
                    b_d.cnt = b_q.cnt + 1'b1;
                end
            end
            B_HOLD: begin
                b_d.st = B_IDLE;
            end
            default: b_d.st = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign ack      = (b_q.st == B_HOLD);
    assign rdata    = b_q.rdata;
    assign cs_n     = (b_q.st == B_IDLE);
    assign rd_n     = !((b_q.st == B_STROBE) && !b_q.wr);
    assign wr_n     = !((b_q.st == B_STROBE) && b_q.wr);
    assign bus_addr = b_q.addr;
    assign dq_o     = b_q.wdata;
    assign dq_oe    = b_q.wr && (b_q.st != B_IDLE);

endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl
    import eeprom_wr_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int WR_MS      = 10,
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64,
    parameter int STROBE_CYC = 2,
    localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [PAGE_W-1:0] host_last,
    input  logic [7:0]        host_wdata,
    output logic [PAGE_W-1:0] host_idx,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [1:0]        fail_code,
    output logic              prot_on,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [7:0]        mem_dq_i
);
    localparam int TMO_CYC = (CLK_HZ / 1000) * WR_MS;

    typedef struct packed {
        ctl_state_e        st;
        phase_e            ph;
        logic [PAGE_W-1:0] idx;
        logic [PAGE_W-1:0] last;
        logic [ADDR_W-1:0] base;
        logic [7:0]        exp_v;
        logic [7:0]        orig;
        logic              prev6;
        logic              done;
        logic              fail;
        logic [1:0]        fcode;
        logic              prot_on;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              bus_req, bus_wr, bus_ack;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata, bus_rdata;
    logic              tmo_clr, tmo_exp;

    eeprom_bus_cycle #(
        .ADDR_W    (ADDR_W),
        .STROBE_CYC(STROBE_CYC)
    ) i_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ack     (bus_ack),
        .rdata   (bus_rdata),
        .cs_n    (mem_cs_n),
        .rd_n    (mem_rd_n),
        .wr_n    (mem_wr_n),
        .bus_addr(mem_addr),
        .dq_o    (mem_dq_o),
        .dq_oe   (mem_dq_oe),
        .dq_i    (mem_dq_i)
    );

    eeprom_wr_timer #(
        .LIMIT(TMO_CYC)
    ) i_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmo_clr),
        .expired(tmo_exp)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.fail  = 1'b0;
        bus_req   = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = c_q.base + ADDR_W'(c_q.idx);
        bus_wdata = 8'h00;
        tmo_clr   = 1'b0;

        unique case (c_q.st)
            S_IDLE: begin
                if (start) begin
                    c_d.idx   = '0;
                    c_d.last  = '0;
                    c_d.base  = host_addr;
                    c_d.ph    = PH_USER;
                    case (mode)
                        MD_BYTE: begin
                            c_d.st    = S_WRITE;
                            c_d.fcode = FC_NONE;
                        end
                        MD_PAGE: begin
                            c_d.st    = S_WRITE;
                            c_d.last  = host_last;
                            c_d.fcode = FC_NONE;
                        end
                        MD_PROBE: begin
                            c_d.st      = S_PROBE;
                            c_d.base    = '0;
                            c_d.fcode   = FC_NONE;
                            c_d.prot_on = 1'b0;
                        end
                        default: c_d.st = S_IDLE;
                    endcase
                end
            end

            S_PROBE: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    c_d.orig = bus_rdata;
                    c_d.ph   = PH_PROBE;
                    c_d.st   = S_WRITE;
                end
            end

            S_WRITE: begin
                bus_req = 1'b1;
                bus_wr  = 1'b1;
                case (c_q.ph)
                    PH_PROBE:   bus_wdata = ~c_q.orig;
                    PH_RESTORE: bus_wdata = c_q.orig;
                    default:    bus_wdata = host_wdata;
                endcase
                if (bus_ack) begin
                    c_d.exp_v = bus_wdata;
                    if (c_q.idx == c_q.last) begin
                        c_d.st  = S_POLL1;
                        tmo_clr = 1'b1;
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                    end
                end
            end

            S_POLL1: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    if (tmo_exp) begin
                        c_d.st    = S_IDLE;
                        c_d.fail  = 1'b1;
                        c_d.fcode = FC_TIMEOUT;
                    end else begin
                        c_d.prev6 = bus_rdata[POLL_BIT];
                        c_d.st    = S_POLL;
                    end
                end
            end

            S_POLL: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    if (bus_rdata[POLL_BIT] == c_q.prev6) begin
                        c_d.st = S_CHECK;
                    end else if (tmo_exp) begin
                        c_d.st    = S_IDLE;
                        c_d.fail  = 1'b1;
                        c_d.fcode = FC_TIMEOUT;
                    end else begin
                        c_d.prev6 = bus_rdata[POLL_BIT];
                    end
                end
            end

            S_CHECK: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    c_d.st = S_IDLE;
                    case (c_q.ph)
                        PH_PROBE: begin
                            if (bus_rdata == c_q.orig) begin
                                c_d.prot_on = 1'b1;
                                c_d.done    = 1'b1;
                            end else if (bus_rdata == ~c_q.orig) begin
                                c_d.ph  = PH_RESTORE;
                                c_d.st  = S_WRITE;
                                c_d.idx = '0;
                            end else begin
                                c_d.fail  = 1'b1;
                                c_d.fcode = FC_VERIFY;
                            end
                        end
                        PH_RESTORE: begin
                            if (bus_rdata == c_q.orig) begin
                                c_d.done = 1'b1;
                            end else begin
                                c_d.fail  = 1'b1;
                                c_d.fcode = FC_VERIFY;
                            end
                        end
                        default: begin
                            if (bus_rdata == c_q.exp_v) begin
                                c_d.done = 1'b1;
                            end else begin
                                c_d.fail  = 1'b1;
                                c_d.fcode = FC_VERIFY;
                            end
                        end
                    endcase
                end
            end

            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign host_idx  = c_q.idx;
    assign busy      = (c_q.st != S_IDLE);
    assign done      = c_q.done;
    assign fail      = c_q.fail;
    assign fail_code = c_q.fcode;
    assign prot_on   = c_q.prot_on;

endmodule

// File: rtl/eeprom_wr_ctrl_chk.sv
module eeprom_wr_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [1:0]        fail_code,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);
    logic       rd_prev_q;
    logic [1:0] rd_falls_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_prev_q  <= 1'b1;
            rd_falls_q <= '0;
        end else begin
            rd_prev_q <= mem_rd_n;
            if (mem_cs_n) begin
                rd_falls_q <= '0;
            end else if (rd_prev_q && !mem_rd_n && rd_falls_q != 2'd3) begin
                rd_falls_q <= rd_falls_q + 1'b1;
            end
        end
    end

    // R1
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n && mem_rd_n && mem_wr_n && !mem_dq_oe));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    // R5
    rd_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_cs_n);

    // R5
    single_rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_falls_q <= 2'd1);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R10
    end_pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> (!busy && !(done && fail)));

    // R7
    fail_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (fail_code != 2'b00));

endmodule

bind eeprom_wr_ctrl eeprom_wr_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .fail_code(fail_code),
    .mem_cs_n (mem_cs_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .mem_dq_oe(mem_dq_oe),
    .mem_addr (mem_addr)
);

// File: tb/test_eeprom_wr_ctrl.sv
module test_eeprom_wr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 8;
    localparam int HZ  = 10000;
    localparam int TMO = (HZ / 1000) * 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [AW-1:0] host_addr = '0;
    logic [5:0] host_last = '0;
    logic [7:0] host_wdata;
    logic [5:0] host_idx;
    logic       busy, done, fail, prot_on;
    logic [1:0] fail_code;
    logic       cs_n, rd_n, wr_n, dq_oe;
    logic [AW-1:0] maddr;
    logic [7:0] dq_o, dq_i;

    logic [7:0] seed = 8'h00;
    assign host_wdata = seed + 8'(int'(host_idx) * 37);

    always #(CLK_PERIOD / 2) clk = ~clk;

    eeprom_wr_ctrl #(
        .CLK_HZ(HZ), .WR_MS(10), .ADDR_W(AW), .PAGE_BYTES(64), .STROBE_CYC(2)
    ) i_eeprom_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .host_addr(host_addr), .host_last(host_last), .host_wdata(host_wdata),
        .host_idx(host_idx), .busy(busy), .done(done), .fail(fail),
        .fail_code(fail_code), .prot_on(prot_on), .mem_cs_n(cs_n),
        .mem_rd_n(rd_n), .mem_wr_n(wr_n), .mem_addr(maddr), .mem_dq_o(dq_o),
        .mem_dq_oe(dq_oe), .mem_dq_i(dq_i)
    );

    // behavioural memory: each write keeps it busy for busy_reload toggling reads
    logic [7:0] mem [256];
    int   busy_left = 0;
    int   busy_reload = 0;
    bit   prot_m = 1'b0;
    bit   corrupt = 1'b0;
    bit   tog = 1'b0;
    logic [7:0] rd_val = 8'h00;
    logic [7:0] lastw = 8'h00;
    int   rd_cnt = 0;
    int   wr_cnt = 0;

    assign dq_i = (!cs_n && !rd_n) ? rd_val : 8'h00;

    always @(negedge rd_n) begin
        if (cs_n === 1'b0) begin
            rd_cnt++;
            if (busy_left > 0) begin
                tog = ~tog;
                rd_val = {~lastw[7], tog, 6'b0};
                busy_left--;
            end else begin
                rd_val = mem[maddr];
            end
        end
    end

    always @(posedge wr_n) begin
        if (cs_n === 1'b0) begin
            wr_cnt++;
            if (!prot_m) begin
                mem[maddr] = corrupt ? (dq_o ^ 8'h01) : dq_o;
                lastw = dq_o;
                busy_left = busy_reload;
            end
        end
    end

    int cyc = 0;
    int done_seen = 0;
    int fail_seen = 0;
    always @(negedge clk) begin
        cyc++;
        if (done) done_seen++;
        if (fail) fail_seen++;
    end

    int checks = 0;
    int errors = 0;
    int elapsed = 0;
    int d0 = 0;
    int f0 = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
        end
    endtask

    task automatic run_op(input logic [1:0] m, input logic [7:0] a, input logic [5:0] l, input logic [7:0] s);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        mode = m; host_addr = a; host_last = l; seed = s;
        d0 = done_seen; f0 = fail_seen;
        elapsed = cyc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20000; k++) begin
            if (done_seen != d0 || fail_seen != f0) break;
            @(negedge clk);
        end
        elapsed = cyc - elapsed;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 190000; k++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(cs_n == 1'b1 && rd_n == 1'b1 && wr_n == 1'b1, "R1 strobes", int'({cs_n, rd_n, wr_n}), 7);
        chk(dq_oe == 1'b0, "R1 oe", int'(dq_oe), 0);

        // R2 / R4 byte writes over device busy lengths
        for (int n = 0; n <= 12; n++) begin
            logic [7:0] a;
            logic [7:0] s;
            a = 8'(8'h90 + n * 3);
            s = 8'(8'h11 * n + 8'h05);
            busy_reload = n;
            run_op(2'b00, a, 6'd17, s);
            chk(done_seen == d0 + 1 && fail_seen == f0, "R2 done", done_seen - d0, 1);
            chk(mem[a] == s, "R2 data", int'(mem[a]), int'(s));
            chk(wr_cnt == 1, "R2 one write", wr_cnt, 1);
            chk(fail_code == 2'b00, "R2 code", int'(fail_code), 0);
            chk(rd_cnt == n + 2 || rd_cnt == n + 3, "R4 poll reads", rd_cnt, n + 2);
            chk(busy == 1'b0, "R1 idle after op", int'(busy), 0);
        end

        // R3 page writes of every length
        for (int l = 0; l < 64; l++) begin
            logic [7:0] s;
            s = 8'(l * 13 + 1);
            for (int i = 8'h40; i < 8'h80; i++) mem[i] = 8'hEE;
            busy_reload = 3;
            run_op(2'b01, 8'h40, 6'(l), s);
            chk(done_seen == d0 + 1, "R3 done", done_seen - d0, 1);
            chk(wr_cnt == l + 1, "R3 write pulses", wr_cnt, l + 1);
            chk(rd_cnt == 5 || rd_cnt == 6, "R3 single wait", rd_cnt, 5);
            for (int i = 0; i < 64; i++) begin
                logic [7:0] e;
                e = (i <= l) ? 8'(s + i * 37) : 8'hEE;
                chk(mem[8'h40 + i] == e, "R3 page byte", int'(mem[8'h40 + i]), int'(e));
            end
        end

        // R10 reserved mode starts nothing
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        mode = 2'b11; host_addr = 8'h30; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R10 reserved busy", int'(busy), 0);
        chk(wr_cnt == 0 && rd_cnt == 0, "R10 reserved bus", wr_cnt + rd_cnt, 0);
        chk(mem[8'h30] == 8'hEE, "R10 reserved mem", int'(mem[8'h30]), 8'hEE);

        // R10 start while busy ignored
        busy_reload = 4;
        for (int i = 8'h80; i < 8'h88; i++) mem[i] = 8'hEE;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        d0 = done_seen; f0 = fail_seen;
        mode = 2'b01; host_addr = 8'h80; host_last = 6'd7; seed = 8'h21; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R10 busy", int'(busy), 1);
        mode = 2'b00; host_addr = 8'h20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            if (done_seen != d0) break;
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
        chk(done_seen == d0 + 1, "R10 one done", done_seen - d0, 1);
        chk(wr_cnt == 8, "R10 ignored start writes", wr_cnt, 8);
        chk(mem[8'h20] == 8'hEE, "R10 ignored addr", int'(mem[8'h20]), 8'hEE);
        chk(mem[8'h87] == 8'(8'h21 + 7 * 37), "R10 burst intact", int'(mem[8'h87]), int'(8'(8'h21 + 7 * 37)));

        // R6 timeout
        busy_reload = 40;
        run_op(2'b00, 8'h50, 6'd0, 8'h3C);
        chk(fail_seen == f0 + 1 && done_seen == d0, "R6 fail no done", fail_seen - f0, 1);
        chk(fail_code == 2'b01, "R6 code", int'(fail_code), 1);
        chk(elapsed >= TMO && elapsed <= TMO + 25, "R6 window", elapsed, TMO);

        // R7 verify mismatch, and code cleared on next start
        busy_left = 0;
        busy_reload = 2;
        corrupt = 1'b1;
        run_op(2'b00, 8'h51, 6'd0, 8'h66);
        chk(fail_seen == f0 + 1, "R7 fail", fail_seen - f0, 1);
        chk(fail_code == 2'b10, "R7 code", int'(fail_code), 2);
        corrupt = 1'b0;
        run_op(2'b00, 8'h52, 6'd0, 8'h67);
        chk(fail_code == 2'b00 && done_seen == d0 + 1, "R7 code cleared", int'(fail_code), 0);

        // R8 / R9 protection probe
        for (int v = 0; v < 4; v++) begin
            logic [7:0] o;
            o = (v == 0) ? 8'hA2 : (v == 1) ? 8'h00 : (v == 2) ? 8'hFF : 8'h5D;
            busy_left = 0;
            busy_reload = 3;
            mem[0] = o;
            prot_m = 1'b0;
            run_op(2'b10, 8'h77, 6'd0, 8'h00);
            chk(done_seen == d0 + 1, "R9 done", done_seen - d0, 1);
            chk(prot_on == 1'b0, "R9 prot off", int'(prot_on), 0);
            chk(mem[0] == o, "R9 restored", int'(mem[0]), int'(o));
            chk(wr_cnt == 2, "R9 two writes", wr_cnt, 2);
            chk(rd_cnt >= 11 && rd_cnt <= 13, "R9 own poll", rd_cnt, 11);

            busy_left = 0;
            prot_m = 1'b1;
            run_op(2'b10, 8'h77, 6'd0, 8'h00);
            chk(done_seen == d0 + 1, "R8 done", done_seen - d0, 1);
            chk(prot_on == 1'b1, "R8 prot on", int'(prot_on), 1);
            chk(mem[0] == o, "R8 unchanged", int'(mem[0]), int'(o));
            chk(wr_cnt == 1, "R8 one write", wr_cnt, 1);
            prot_m = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

endmodule